// File: doc/BRIEF.md
# Active-Video Byte Serializer with Elastic Buffer

This block takes 4:2:2 pixel pairs from the decoder's sample-rate path and sends them out as a single 8-bit byte stream, one byte per system clock. Only pairs flagged as belonging to the active picture are kept. Samples from horizontal and vertical blanking are discarded before they reach storage. A 32-entry elastic buffer absorbs the difference between the bursty arrival of pixel pairs and the steady byte clock.

Each accepted pair is stored as one 32-bit entry. It is unpacked into four consecutive bytes in the order Cb, Y0, Cr, Y1, so a pair is never split across two entries. A valid strobe marks every clock that carries a real byte. An active strobe stays high for as long as the mode is enabled. Dropping the mode enable flushes the buffer and the byte phase, so the next enable starts from a clean Cb byte.

Top module: `burst_byte_packer`

## Requirements
- R1: Each stored pair is emitted on four consecutive valid clocks as Cb, Y0, Cr, Y1. The entry is packed {Y1, Cr, Y0, Cb}, with Cb in bits 7:0.
- R2: A pair presented with `pix_vld` high and `pix_active` low is discarded and never appears on the output.
- R3: A pair accepted while 32 entries are held is dropped. In that cycle `ovf` sets, and it stays set until the mode is disabled.
- R4: `byte_vld` is high exactly when `mode_en` is high and the buffer holds at least one entry. A pair written at a clock edge is visible from the next cycle.
- R5: `active` equals `mode_en` on every cycle.
- R6: While `mode_en` is low, the buffer is emptied and the byte phase and `ovf` are cleared. The first byte after re-enabling is a Cb byte.
- R7: The buffer holds up to 32 entries without loss.
- R8: `byte_out` is zero on every cycle where `byte_vld` is low.
- R9: When a write and the pop after a Y1 byte fall in the same clock, both take effect and the entry count is unchanged.
- R10: After reset, `byte_vld` and `ovf` are low and the buffer is empty.
- R11: Pairs presented while `mode_en` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Enables the byte-serial mode |
| pix_vld | input | 1 | A pixel pair is presented this cycle |
| pix_active | input | 1 | The presented pair lies in active video |
| pix_y0 | input | 8 | First luma sample of the pair |
| pix_cb | input | 8 | Blue-difference chroma of the pair |
| pix_y1 | input | 8 | Second luma sample of the pair |
| pix_cr | input | 8 | Red-difference chroma of the pair |
| byte_out | output | 8 | Serialized byte |
| byte_vld | output | 1 | byte_out carries a valid active byte |
| active | output | 1 | High while the mode is enabled |
| ovf | output | 1 | Sticky flag: a pair was lost to a full buffer |

## Verification
The cycle of interest is the one where a new pair is written and, at the same edge, the head entry is popped after its Y1 byte. It also matters when that write meets a buffer that is already full. The bench provokes the first case by writing exactly every fourth clock in step with the byte phase. It provokes the second by writing on every clock until the buffer saturates. A behavioural queue model judges both cases clock by clock: it compares the byte, the valid flag and the sticky overflow flag, which reveals whether the pop and the write each took effect or whether a pair went missing.

// File: rtl/burst_byte_packer.sv
module burst_byte_packer #(
  parameter int DEPTH = 32,
  parameter int BW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          pix_vld,
  input  logic          pix_active,
  input  logic [BW-1:0] pix_y0,
  input  logic [BW-1:0] pix_cb,
  input  logic [BW-1:0] pix_y1,
  input  logic [BW-1:0] pix_cr,
  output logic [BW-1:0] byte_out,
  output logic          byte_vld,
  output logic          active,
  output logic          ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = 4 * BW;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic [1:0]    phase;
  logic          ovf_q;

  wire           full   = count == (AW+1)'(DEPTH);
  wire           wr_req = mode_en && pix_vld && pix_active;
  wire           push   = wr_req && !full;
  wire           pop    = byte_vld && phase == 2'd3;
  wire [EW-1:0]  head   = mem[rd_ptr];

  assign byte_vld = mode_en && count != '0;
  assign active   = mode_en;
  assign ovf      = ovf_q;
  assign byte_out = byte_vld ? head[phase*BW +: BW] : '0;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {pix_y1, pix_cr, pix_y0, pix_cb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      phase  <= '0;
      ovf_q  <= 1'b0;
    end else if (!mode_en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      phase  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      if (byte_vld) phase <= phase + 1'b1;
      if (wr_req && full) ovf_q <= 1'b1;
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && mode_en) |=> ovf);

  a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && full && !pop) |=> count == (AW+1)'(DEPTH));

  a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (!byte_vld && !ovf && phase == 2'd0));

  a_r1_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && !byte_vld) |=> $stable(phase));

  a_r9_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && push && pop) |=> $stable(count));

  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |-> byte_out == '0);
endmodule

// File: tb/tb_burst_byte_packer.sv
module tb_burst_byte_packer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_en = 1'b0, pix_vld = 1'b0, pix_active = 1'b0;
  logic [7:0] pix_y0 = '0, pix_cb = '0, pix_y1 = '0, pix_cr = '0;
  logic [7:0] byte_out;
  logic byte_vld, active, ovf;

  int tests = 0, fails = 0;
  int seq = 0;
  logic [31:0] q[$];
  int ph = 0;
  bit movf = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  burst_byte_packer dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .pix_vld(pix_vld),
    .pix_active(pix_active), .pix_y0(pix_y0), .pix_cb(pix_cb),
    .pix_y1(pix_y1), .pix_cr(pix_cr), .byte_out(byte_out),
    .byte_vld(byte_vld), .active(active), .ovf(ovf)
  );

  always @(posedge clk) begin
    if (!rst_n || !mode_en) begin
      q.delete();
      ph = 0;
      movf = 1'b0;
    end else begin
      bit was_full, do_pop;
      was_full = q.size() == 32;
      do_pop = q.size() != 0 && ph == 3;
      if (q.size() != 0) ph = (ph + 1) % 4;
      if (do_pop) void'(q.pop_front());
      if (pix_vld && pix_active) begin
        if (was_full) movf = 1'b1;
        else q.push_back({pix_y1, pix_cr, pix_y0, pix_cb});
      end
    end
  end

  task automatic chk(string req, string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t got %h exp %h", req, tag, $time, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit m, bit v, bit a, string tag);
    logic [31:0] w;
    logic ev;
    @(negedge clk);
    rst_n = r;
    mode_en = m;
    pix_vld = v;
    pix_active = a;
    pix_cb = 8'(seq * 7 + 1);
    pix_y0 = 8'(seq + 16);
    pix_cr = 8'(seq * 3 + 128);
    pix_y1 = 8'(seq ^ 8'hA5);
    if (v) seq++;
    #1;
    ev = r && m && q.size() != 0;
    w = (q.size() != 0) ? q[0] : 32'h0;
    chk("R4", tag, {7'b0, byte_vld}, {7'b0, ev});
    chk("R1", tag, byte_out, ev ? w[ph*8 +: 8] : 8'h00);
    chk("R5", tag, {7'b0, active}, {7'b0, m});
    chk("R3", tag, {7'b0, ovf}, {7'b0, movf});
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R10");
    for (int i = 0; i < 6; i++) cyc(1, 0, 1, 1, "R11 R8");
    for (int i = 0; i < 48; i++) cyc(1, 1, (i % 4) == 0, 1, "R9 R1");
    for (int i = 0; i < 48; i++) cyc(1, 1, (i % 2) == 0, (i % 6) < 2, "R2");
    for (int i = 0; i < 60; i++) cyc(1, 1, 1, 1, "R7 R3");
    for (int i = 0; i < 140; i++) cyc(1, 1, 0, 0, "R4 R8");
    for (int i = 0; i < 10; i++) cyc(1, 1, 1, 1, "R6");
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0, "R6");
    for (int i = 0; i < 20; i++) cyc(1, 1, (i % 3) == 0, 1, "R6");
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(1, lfsr[7:0] != 8'h00, lfsr[0] & lfsr[3], lfsr[5] | lfsr[9], "R5 mix");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule